// File: doc/BRIEF.md
# Receive-Side Frame Sequence and Integrity Checker

This block sits on the receive side of a data link layer. Frames arrive one 32-bit word per cycle. Every frame has a fixed shape. It opens with a header word that carries a 12-bit sequence number. Eight payload words follow, and a 32-bit check word closes the frame. The block recomputes the CRC over the sequence number and the payload, then compares the header's sequence number with the one it expects next.

A frame whose CRC matches and whose number is the expected one is handed upward as a single wide payload vector, and the frame's number is acknowledged. There are two ways the block can learn that data was lost. The first is a CRC mismatch. The second is a good frame whose number runs ahead of the expected one, which means something was dropped. In either case the block emits a restart request naming the first missing number. It then discards everything until a clean frame with that number arrives.

A good frame that is behind the expected number is a duplicate. It is dropped without comment.

Top module: `llrx_link_rx`

## Requirements
- R1: After reset, all output pulses are low and the expected sequence number is 0. A first frame that carries any other number therefore triggers a restart request for number 0.
- R2: The CRC uses generator 0x04C11DB7 and starts from all ones. It shifts MSB-first over the 12 low bits of the header word (bits 11:0 hold the sequence number; bits 31:12 are ignored), then over each payload word MSB-first. There is no final inversion. If the last word of a frame equals this value and the sequence number matches, `dlv_valid` pulses for one cycle, in the cycle after that last word is taken. With the pulse, `dlv_seq` gives the frame's number and `dlv_payload` gives payload word k in bits 32k+31:32k.
- R3: Each delivery is accompanied in the same cycle by `ack_valid`, and `ack_seq` equals the delivered number. The expected number then advances by one.
- R4: While no restart is pending, a frame with a bad CRC raises `rsend_req` for one cycle, and `rsend_seq` equals the expected number. Nothing is delivered.
- R5: While no restart is pending, a good-CRC frame whose number is ahead of the expected one raises a restart request naming the expected number. A number is ahead when (number − expected) mod 4096 lies in 1..2048. Nothing is delivered.
- R6: While a restart is pending, every frame is dropped without a new request, including frames with a bad CRC. This lasts until a good-CRC frame carrying the requested number arrives. That frame is delivered and ends the pending state.
- R7: A good-CRC frame whose number is behind the expected one is a duplicate. It is behind when (expected − number) mod 4096 lies in 1..2047. A duplicate produces no delivery, no acknowledge and no request, and it leaves the expected number unchanged.
- R8: The sequence number wraps modulo 4096, so after 4095 is accepted the next expected number is 0.
- R9: A word with `in_sof` high always begins a new frame and abandons any partial one. Words with `in_valid` high and `in_sof` low that arrive outside a frame are ignored.
- R10: Frames may follow each other with no idle cycle, and each is judged against the expected number left by its predecessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame word is present this cycle |
| in_sof | input | 1 | The present word is a frame's header |
| in_data | input | 32 | Frame word |
| dlv_valid | output | 1 | One-cycle pulse: a frame was accepted |
| dlv_seq | output | 12 | Sequence number of the accepted frame |
| dlv_payload | output | 256 | Payload of the accepted frame, word 0 lowest |
| ack_valid | output | 1 | One-cycle acknowledge pulse |
| ack_seq | output | 12 | Last accepted sequence number |
| rsend_req | output | 1 | One-cycle restart request |
| rsend_seq | output | 12 | Sequence number to resume from |

## Verification
Two things can fall in the same cycle: the verdict on one frame, taken from its check word, and the intake of the next frame's header. The risk is that the second frame is judged against a stale expected number. This is provoked by sending two in-order frames back to back with no idle cycle, at the end of a recovery and otherwise. It is judged by requiring two deliveries with consecutive numbers and no restart request. A mid-frame header is also injected, so that a new start meets a partly received frame; only the fresh frame may be judged.

// File: rtl/llrx_pkg.sv
package llrx_pkg;

    localparam int WORD_W   = 32;
    localparam int CRC_W    = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

    typedef enum logic [1:0] {
        SEQ_MATCH = 2'd0,
        SEQ_OLD   = 2'd1,
        SEQ_AHEAD = 2'd2
    } seq_class_e;

    typedef enum logic {
        RX_NORMAL  = 1'b0,
        RX_RECOVER = 1'b1
    } rx_mode_e;

    // Shift nbits of d (MSB of the used field first) through the CRC register.
    function automatic logic [CRC_W-1:0] crc_feed(
        input logic [CRC_W-1:0]  c,
        input logic [WORD_W-1:0] d,
        input int                nbits
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (i < nbits) begin
                fb = r[CRC_W-1] ^ d[i];
                r  = {r[CRC_W-2:0], 1'b0};
                if (fb) r = r ^ CRC_POLY;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/llrx_crc_acc.sv
module llrx_crc_acc
    import llrx_pkg::*;
#(
    parameter int SEQ_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              first,
    input  logic [WORD_W-1:0] data,
    output logic [CRC_W-1:0]  crc_q
);

    logic [CRC_W-1:0] crc_d;

    always_comb begin
        crc_d = crc_q;
        if (step) begin
            if (first) crc_d = crc_feed('1, data, SEQ_W);
            else       crc_d = crc_feed(crc_q, data, WORD_W);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    // Running CRC must only move when a covered word is taken.
    assert_crc_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(crc_q));

endmodule

// File: rtl/llrx_seq_judge.sv
module llrx_seq_judge
    import llrx_pkg::*;
#(
    parameter int SEQ_W = 12
) (
    input  logic [SEQ_W-1:0] seq,
    input  logic [SEQ_W-1:0] expected,
    output seq_class_e       cls
);

    localparam logic [SEQ_W-1:0] HALF = SEQ_W'(1) << (SEQ_W - 1);

    logic [SEQ_W-1:0] behind;

    always_comb begin
        behind = expected - seq;
        if (behind == '0)        cls = SEQ_MATCH;
        else if (behind < HALF)  cls = SEQ_OLD;
        else                     cls = SEQ_AHEAD;
    end

endmodule

// File: rtl/llrx_link_rx.sv
module llrx_link_rx
    import llrx_pkg::*;
#(
    parameter int SEQ_W     = 12,
    parameter int PAY_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sof,
    input  logic [WORD_W-1:0]           in_data,
    output logic                        dlv_valid,
    output logic [SEQ_W-1:0]            dlv_seq,
    output logic [PAY_WORDS*WORD_W-1:0] dlv_payload,
    output logic                        ack_valid,
    output logic [SEQ_W-1:0]            ack_seq,
    output logic                        rsend_req,
    output logic [SEQ_W-1:0]            rsend_seq
);

    localparam int FRAME_WORDS = PAY_WORDS + 2;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    typedef struct packed {
        rx_mode_e                           mode;
        logic                               in_frame;
        logic [IDX_W-1:0]                   cnt;
        logic [SEQ_W-1:0]                   exp_seq;
        logic [SEQ_W-1:0]                   hdr_seq;
        logic [PAY_WORDS-1:0][WORD_W-1:0]   pay;
        logic                               dlv_valid;
        logic [SEQ_W-1:0]                   dlv_seq;
        logic                               ack_valid;
        logic [SEQ_W-1:0]                   ack_seq;
        logic                               rsend_req;
        logic [SEQ_W-1:0]                   rsend_seq;
    } rx_state_t;

    rx_state_t        st_d, st_q;
    logic             take;
    logic [IDX_W-1:0] idx;
    logic [CRC_W-1:0] crc_q;
    logic             crc_ok;
    seq_class_e       cls;

    assign take = in_valid && (in_sof || st_q.in_frame);
    assign idx  = in_sof ? '0 : st_q.cnt;

    llrx_crc_acc #(.SEQ_W(SEQ_W)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (take && (idx != LAST_IDX)),
        .first (in_sof),
        .data  (in_data),
        .crc_q (crc_q)
    );

    llrx_seq_judge #(.SEQ_W(SEQ_W)) u_judge (
        .seq      (st_q.hdr_seq),
        .expected (st_q.exp_seq),
        .cls      (cls)
    );

    assign crc_ok = (in_data == crc_q);

    always_comb begin
        st_d           = st_q;
        st_d.dlv_valid = 1'b0;
        st_d.ack_valid = 1'b0;
        st_d.rsend_req = 1'b0;
        if (take) begin
            st_d.in_frame = 1'b1;
            st_d.cnt      = IDX_W'(idx + 1'b1);
            if (idx == '0) st_d.hdr_seq = in_data[SEQ_W-1:0];
            for (int k = 0; k < PAY_WORDS; k++) begin
                if (idx == IDX_W'(k + 1)) st_d.pay[k] = in_data;
            end
            if (idx == LAST_IDX) begin
                st_d.in_frame = 1'b0;
                st_d.cnt      = '0;
                if (crc_ok && cls == SEQ_MATCH) begin
                    st_d.dlv_valid = 1'b1;
                    st_d.dlv_seq   = st_q.hdr_seq;
                    st_d.ack_valid = 1'b1;
                    st_d.ack_seq   = st_q.hdr_seq;
                    st_d.exp_seq   = st_q.exp_seq + 1'b1;
                    st_d.mode      = RX_NORMAL;
                end else if (st_q.mode == RX_NORMAL &&
                             (!crc_ok || cls == SEQ_AHEAD)) begin
                    st_d.rsend_req = 1'b1;
                    st_d.rsend_seq = st_q.exp_seq;
                    st_d.mode      = RX_RECOVER;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dlv_valid   = st_q.dlv_valid;
    assign dlv_seq     = st_q.dlv_seq;
    assign dlv_payload = st_q.pay;
    assign ack_valid   = st_q.ack_valid;
    assign ack_seq     = st_q.ack_seq;
    assign rsend_req   = st_q.rsend_req;
    assign rsend_seq   = st_q.rsend_seq;

    assert_deliver_after_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> $past(in_valid));

    assert_deliver_expected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_seq == $past(st_q.exp_seq));

    assert_ack_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> st_q.exp_seq == SEQ_W'(ack_seq + 1'b1));

    assert_request_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsend_req |-> (st_q.exp_seq == rsend_seq) && (st_q.mode == RX_RECOVER));

    assert_no_mixed_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dlv_valid && rsend_req));

    assert_single_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsend_req |-> $past(st_q.mode) == RX_NORMAL);

endmodule

// File: tb/tb_llrx_link_rx.sv
module tb_llrx_link_rx;

    localparam int SEQ_W = 12;
    localparam int PW    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic [31:0]       in_data = '0;
    logic              dlv_valid;
    logic [SEQ_W-1:0]  dlv_seq;
    logic [PW*32-1:0]  dlv_payload;
    logic              ack_valid;
    logic [SEQ_W-1:0]  ack_seq;
    logic              rsend_req;
    logic [SEQ_W-1:0]  rsend_seq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic              s_dv, s_ack, s_rr;
    logic [SEQ_W-1:0]  s_dseq, s_aseq, s_rseq;
    logic [PW*32-1:0]  s_pay;

    always #2 clk = ~clk;

    llrx_link_rx #(.SEQ_W(SEQ_W), .PAY_WORDS(PW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .dlv_valid(dlv_valid), .dlv_seq(dlv_seq),
        .dlv_payload(dlv_payload), .ack_valid(ack_valid), .ack_seq(ack_seq),
        .rsend_req(rsend_req), .rsend_seq(rsend_seq)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pay_word(input int seq, input int k);
        return 32'h5A5A_0000 ^ (seq * 32'h0100_0193) ^ ((k + 1) * 32'h9E37_79B9);
    endfunction

    function automatic logic [PW*32-1:0] pay_vec(input int seq);
        logic [PW*32-1:0] v;
        for (int k = 0; k < PW; k++) v[k*32 +: 32] = pay_word(seq, k);
        return v;
    endfunction

    function automatic logic [31:0] ref_crc(input int seq);
        logic [31:0] c;
        logic [31:0] w;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int b = SEQ_W - 1; b >= 0; b--) begin
            fb = c[31] ^ seq[b];
            c  = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        for (int k = 0; k < PW; k++) begin
            w = pay_word(seq, k);
            for (int b = 31; b >= 0; b--) begin
                fb = c[31] ^ w[b];
                c  = c << 1;
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    task automatic sample();
        s_dv = dlv_valid; s_dseq = dlv_seq; s_pay = dlv_payload;
        s_ack = ack_valid; s_aseq = ack_seq;
        s_rr = rsend_req; s_rseq = rsend_seq;
    endtask

    // Drives whole frame from the current negedge; samples verdict at the negedge after.
    task automatic send_frame(input int seq, input bit bad);
        for (int i = 0; i < PW + 2; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0);
            if (i == 0)           in_data = {20'hC3A5F, seq[SEQ_W-1:0]};
            else if (i <= PW)     in_data = pay_word(seq, i - 1);
            else                  in_data = ref_crc(seq) ^ (bad ? 32'h0000_0100 : 32'h0);
            @(negedge clk);
        end
        sample();
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic expect_accept(input int seq, input string req);
        check(s_dv == 1'b1, req, s_dv, 1);
        check(s_dseq == seq[SEQ_W-1:0], req, s_dseq, seq);
        check(s_pay == pay_vec(seq), req, s_pay[63:0], pay_vec(seq) & 64'hFFFF_FFFF_FFFF_FFFF);
        check(s_ack == 1'b1 && s_aseq == seq[SEQ_W-1:0], req, {s_ack, s_aseq}, {1'b1, seq[SEQ_W-1:0]});
        check(s_rr == 1'b0, req, s_rr, 0);
    endtask

    task automatic expect_request(input int seq, input string req);
        check(s_rr == 1'b1 && s_rseq == seq[SEQ_W-1:0], req, {s_rr, s_rseq}, {1'b1, seq[SEQ_W-1:0]});
        check(s_dv == 1'b0 && s_ack == 1'b0, req, {s_dv, s_ack}, 0);
    endtask

    task automatic expect_silent(input string req);
        check(s_dv == 1'b0 && s_ack == 1'b0 && s_rr == 1'b0, req, {s_dv, s_ack, s_rr}, 0);
    endtask

    task automatic t_reset_R1();
        sample();
        expect_silent("R1 reset outputs");
        send_frame(1, 1'b0);
        expect_request(0, "R1 expected starts at 0");
        send_frame(0, 1'b0);
        expect_accept(0, "R6 requested frame ends recovery");
    endtask

    task automatic t_accept_R2_R3();
        send_frame(1, 1'b0);
        expect_accept(1, "R2 R3 in-order frame");
    endtask

    task automatic t_crc_error_R4();
        send_frame(2, 1'b1);
        expect_request(2, "R4 bad CRC requests restart");
        send_frame(3, 1'b0);
        expect_silent("R6 other number dropped while pending");
        send_frame(2, 1'b1);
        expect_silent("R6 bad CRC while pending no new request");
        send_frame(2, 1'b0);
        expect_accept(2, "R6 resume at requested number");
    endtask

    task automatic t_gap_R5();
        send_frame(5, 1'b0);
        expect_request(3, "R5 gap requests missing number");
        send_frame(3, 1'b0);
        expect_accept(3, "R6 gap recovery");
    endtask

    task automatic t_duplicate_R7();
        send_frame(1, 1'b0);
        expect_silent("R7 duplicate dropped");
        send_frame(4, 1'b0);
        expect_accept(4, "R7 expected unchanged by duplicate");
    endtask

    task automatic t_restart_sof_R9();
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_data  = (i == 0) ? {20'h0, 12'd9} : 32'hDEAD_0000 + i;
            @(negedge clk);
        end
        send_frame(5, 1'b0);
        expect_accept(5, "R9 new start abandons partial frame");
        for (int i = 0; i < 12; i++) begin
            in_valid = 1'b1;
            in_sof   = 1'b0;
            in_data  = ref_crc(6);
            @(negedge clk);
            sample();
            expect_silent("R9 stray words ignored");
        end
        in_valid = 1'b0;
        @(negedge clk);
        send_frame(6, 1'b0);
        expect_accept(6, "R9 next frame after stray words");
    endtask

    task automatic t_back_to_back_R10();
        send_frame(7, 1'b0);
        expect_accept(7, "R10 first of pair");
        send_frame(8, 1'b0);
        expect_accept(8, "R10 second of pair");
    endtask

    task automatic t_wrap_R8();
        int bad;
        bad = 0;
        for (int s = 9; s < 4096; s++) begin
            send_frame(s, 1'b0);
            if (!(s_dv && s_dseq == s[SEQ_W-1:0] && s_ack && !s_rr)) bad++;
        end
        check(bad == 0, "R8 long in-order run", bad, 0);
        check(s_aseq == 12'hFFF, "R8 last before wrap", s_aseq, 12'hFFF);
        send_frame(0, 1'b0);
        expect_accept(0, "R8 number wraps to 0");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_accept_R2_R3();
        t_crc_error_R4();
        t_gap_R5();
        t_duplicate_R7();
        t_restart_sof_R9();
        t_back_to_back_R10();
        t_wrap_R8();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule